// File: doc/BRIEF.md
# Block and Page Address Translator

This block maps a 32-bit effective address to a physical address along two paths evaluated in the same cycle. The first path is a small array of variable-size block mappings. Every entry is compared against the address at once, and each entry can cover any power-of-two region from 128 KB up to 256 MB. The second path is a 64-entry page buffer of 4 KB pages, organised as 32 sets of two ways. Each set keeps one least-recently-used bit, which picks the way that a refill overwrites.

A lookup is presented with a valid strobe and an address. One clock later, a registered result reports the physical address, whether a translation was found, and which path supplied it. When both paths hit, the block mapping is used. When neither hits, a miss flag is raised and the physical address carries no meaning. Software-side agents load block entries through one write port and refill page entries through another. The instruction and data sides each use their own instance.

Top module: `xlate_top`

## Requirements
- R1: After synchronous reset, res_valid, res_hit and res_miss are 0, and every block entry and page entry is invalid, so a lookup misses.
- R2: res_valid is 1 exactly in the cycle after a cycle with lk_valid = 1, and is 0 otherwise.
- R3: A valid block entry matches when EA[31:28] equals the stored base and EA[27:17] equals the stored base at every bit where the size mask is 0. The result then has res_src = 1 (block). PA[31:17] takes the physical base where the mask is 0 and EA where the mask is 1, and PA[16:0] = EA[16:0].
- R4: When several block entries match, the lowest-numbered entry supplies the translation.
- R5: A page hit occurs when a valid way of the set selected by EA[16:12] holds tag EA[31:17]. The result is res_src = 0 (page) and PA = {stored frame, EA[11:0]}.
- R6: When the block path and the page path both hit, the block translation is returned with res_src = 1.
- R7: When neither path hits, res_miss = 1 and res_hit = 0. On every valid result, exactly one of res_hit and res_miss is 1.
- R8: A refill writes the way named by the set's LRU bit, and that way becomes most recently used.
- R9: A page hit makes the other way of that set least recently used. If a refill to the same set occurs in the same cycle, the refill's update wins.
- R10: A block entry written with its valid bit at 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_ea | input | 32 | Effective address to translate |
| bw_en | input | 1 | Block entry write strobe |
| bw_idx | input | 2 | Block entry index to write |
| bw_valid | input | 1 | Valid bit written into the entry |
| bw_ebase | input | 15 | Effective base, address bits 31:17 |
| bw_pbase | input | 15 | Physical base, address bits 31:17 |
| bw_mask | input | 11 | Size mask over bits 27:17, 1 = bit passes from EA |
| pw_en | input | 1 | Page buffer refill strobe |
| pw_vpn | input | 20 | Virtual page number (EA bits 31:12) to install |
| pw_ppn | input | 20 | Physical frame number for that page |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | A translation was found |
| res_miss | output | 1 | Neither path translated the address |
| res_src | output | 1 | 1 = block path, 0 = page path |
| res_pa | output | 32 | Translated physical address |

## Verification
The bench builds the block with its default parameters: four block entries, 32 page sets, 4 KB pages and block sizes from 128 KB to 256 MB. With these values it can use a 128 KB mapping, a whole-256 MB mapping and a 2 MB mapping that overlaps it, which exercises the mask pass-through at both ends of the size range as well as the priority between overlapping entries. Several virtual pages that share set 5 drive the LRU bit through hits and refills. Evicted pages show up as misses, which makes the replacement order visible at the ports.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic {
    SRC_PAGE  = 1'b0,
    SRC_BLOCK = 1'b1
  } src_e;

  localparam int unsigned WAYS = 2;
endpackage

// File: rtl/xlate_blk.sv
module xlate_blk #(
  parameter int unsigned BLK_N = 4,
  parameter int unsigned UP_W  = 15,
  parameter int unsigned MSK_W = 11,
  localparam int unsigned IDX_W = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [UP_W-1:0]  wr_ebase,
  input  logic [UP_W-1:0]  wr_pbase,
  input  logic [MSK_W-1:0] wr_mask,
  input  logic [UP_W-1:0]  ea_up,
  output logic             hit,
  output logic [UP_W-1:0]  pa_up
);
  localparam int unsigned FIX_W = UP_W - MSK_W;

  logic [BLK_N-1:0] vld_q;
  logic [UP_W-1:0]  eb_q [BLK_N];
  logic [UP_W-1:0]  pb_q [BLK_N];
  logic [UP_W-1:0]  mx_q [BLK_N];
  logic [BLK_N-1:0] match;
  logic [IDX_W-1:0] sel;

  // Valid bits carry a reset; the entry contents are plain storage
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      eb_q[wr_idx] <= wr_ebase;
      pb_q[wr_idx] <= wr_pbase;
      mx_q[wr_idx] <= {{FIX_W{1'b0}}, wr_mask};
    end
  end

  // One comparator per entry, all operating in parallel
  for (genvar i = 0; i < BLK_N; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (((ea_up ^ eb_q[i]) & ~mx_q[i]) == '0);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest match
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = BLK_N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign pa_up = (pb_q[sel] & ~mx_q[sel]) | (ea_up & mx_q[sel]);

  // R4: the chosen entry matches and no lower entry does
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match[sel] && ((match & ((BLK_N'(1) << sel) - BLK_N'(1))) == '0)));

  // R10: an entry written invalid cannot match on the next cycle
  a_r10_invalid_silent: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_valid) |=> !match[$past(wr_idx)]);
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int unsigned SETS  = 32,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned TAG_W = VPN_W - SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  input  logic             pw_en,
  input  logic [VPN_W-1:0] pw_vpn,
  input  logic [PPN_W-1:0] pw_ppn
);
  import xlate_pkg::*;

  logic [SET_W-1:0] lk_set, pw_set;
  logic [TAG_W-1:0] lk_tag, pw_tag;
  logic [WAYS-1:0]  way_hit;
  logic [PPN_W-1:0] rd_ppn [WAYS];
  logic [SETS-1:0]  lru_q;
  logic             victim;
  logic             hit_way;

  assign lk_set = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];
  assign pw_set = pw_vpn[SET_W-1:0];
  assign pw_tag = pw_vpn[VPN_W-1:SET_W];
  assign victim = lru_q[pw_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_m [SETS];
    logic [PPN_W-1:0] ppn_m [SETS];
    logic [SETS-1:0]  vld_q;
    logic             wr_here;

    assign wr_here = pw_en && (victim == w[0]);

    // Tag and frame arrays: write-only in clocked logic, read asynchronously
    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_m[pw_set] <= pw_tag;
        ppn_m[pw_set] <= pw_ppn;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else if (wr_here) vld_q[pw_set] <= 1'b1;
    end

    assign way_hit[w] = vld_q[lk_set] && (tag_m[lk_set] == lk_tag);
    assign rd_ppn[w]  = ppn_m[lk_set];
  end

  assign hit     = |way_hit;
  assign hit_way = !way_hit[0];
  assign ppn     = rd_ppn[hit_way];

  // LRU bit names the way to replace; a refill's update comes last and wins
  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else begin
      if (lk_en && hit) lru_q[lk_set] <= !hit_way;
      if (pw_en)        lru_q[pw_set] <= !victim;
    end
  end

  // R8: the refilled way is most recently used afterwards
  a_r8_refill_mru: assert property (@(posedge clk) disable iff (rst)
    pw_en |=> (lru_q[$past(pw_set)] != $past(victim)));

  // R9: a page hit leaves the other way as replacement candidate
  a_r9_hit_lru: assert property (@(posedge clk) disable iff (rst)
    (lk_en && hit && !(pw_en && pw_set == lk_set)) |=> (lru_q[$past(lk_set)] != $past(hit_way)));
endmodule

// File: rtl/xlate_top.sv
module xlate_top #(
  parameter int unsigned EA_W    = 32,
  parameter int unsigned BLK_N   = 4,
  parameter int unsigned BLK_MIN = 17,
  parameter int unsigned BLK_MAX = 28,
  parameter int unsigned PG_W    = 12,
  parameter int unsigned SETS    = 32,
  localparam int unsigned UP_W  = EA_W - BLK_MIN,
  localparam int unsigned MSK_W = BLK_MAX - BLK_MIN,
  localparam int unsigned VPN_W = EA_W - PG_W,
  localparam int unsigned IDX_W = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [EA_W-1:0]  lk_ea,
  input  logic             bw_en,
  input  logic [IDX_W-1:0] bw_idx,
  input  logic             bw_valid,
  input  logic [UP_W-1:0]  bw_ebase,
  input  logic [UP_W-1:0]  bw_pbase,
  input  logic [MSK_W-1:0] bw_mask,
  input  logic             pw_en,
  input  logic [VPN_W-1:0] pw_vpn,
  input  logic [VPN_W-1:0] pw_ppn,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_src,
  output logic [EA_W-1:0]  res_pa
);
  import xlate_pkg::*;

  logic             blk_hit;
  logic [UP_W-1:0]  blk_pa;
  logic             pg_hit;
  logic [VPN_W-1:0] pg_ppn;
  logic             any_hit;

  xlate_blk #(.BLK_N(BLK_N), .UP_W(UP_W), .MSK_W(MSK_W)) u_blk (
    .clk(clk), .rst(rst),
    .wr_en(bw_en), .wr_idx(bw_idx), .wr_valid(bw_valid),
    .wr_ebase(bw_ebase), .wr_pbase(bw_pbase), .wr_mask(bw_mask),
    .ea_up(lk_ea[EA_W-1:BLK_MIN]),
    .hit(blk_hit), .pa_up(blk_pa)
  );

  xlate_tlb #(.SETS(SETS), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_tlb (
    .clk(clk), .rst(rst),
    .lk_en(lk_valid), .lk_vpn(lk_ea[EA_W-1:PG_W]),
    .hit(pg_hit), .ppn(pg_ppn),
    .pw_en(pw_en), .pw_vpn(pw_vpn), .pw_ppn(pw_ppn)
  );

  assign any_hit = blk_hit || pg_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_src   <= SRC_PAGE;
      res_pa    <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_hit;
      res_miss  <= lk_valid && !any_hit;
      res_src   <= blk_hit ? SRC_BLOCK : SRC_PAGE;
      res_pa    <= blk_hit ? {blk_pa, lk_ea[BLK_MIN-1:0]} : {pg_ppn, lk_ea[PG_W-1:0]};
    end
  end

  // R2: one-cycle registered result
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  // R7: hit and miss are exclusive and complete on a valid result
  a_r7_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit != res_miss));
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_miss));

  // R6: a block hit decides the source even when the page path also hits
  a_r6_block_first: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && blk_hit) |=> (res_hit && res_src == SRC_BLOCK));
endmodule

// File: tb/tb_xlate_top.sv
module tb_xlate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        bw_en = 1'b0;
  logic [1:0]  bw_idx = '0;
  logic        bw_valid = 1'b0;
  logic [14:0] bw_ebase = '0;
  logic [14:0] bw_pbase = '0;
  logic [10:0] bw_mask = '0;
  logic        pw_en = 1'b0;
  logic [19:0] pw_vpn = '0;
  logic [19:0] pw_ppn = '0;
  logic        res_valid, res_hit, res_miss, res_src;
  logic [31:0] res_pa;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  xlate_top dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ea(lk_ea),
    .bw_en(bw_en), .bw_idx(bw_idx), .bw_valid(bw_valid),
    .bw_ebase(bw_ebase), .bw_pbase(bw_pbase), .bw_mask(bw_mask),
    .pw_en(pw_en), .pw_vpn(pw_vpn), .pw_ppn(pw_ppn),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_src(res_src), .res_pa(res_pa)
  );

  typedef struct packed {
    logic [31:0] ea;
    logic        hit;
    logic        src;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_1234, 1'b1, 1'b1, 32'h0010_1234},  // R3 128 KB block
    '{32'h8002_0000, 1'b0, 1'b0, 32'h0000_0000},  // R7 compared bit 17 differs
    '{32'h9ABC_DEF0, 1'b1, 1'b1, 32'h2ABC_DEF0},  // R3 256 MB block pass-through
    '{32'h9000_5000, 1'b1, 1'b1, 32'h2000_5000},  // R4 entries 1 and 2 overlap
    '{32'h1234_5678, 1'b1, 1'b0, 32'hABCD_E678},  // R5 page way 0
    '{32'h5432_5FFF, 1'b1, 1'b0, 32'h2222_2FFF},  // R5 page way 1 same set
    '{32'h8000_1ABC, 1'b1, 1'b1, 32'h0010_1ABC},  // R6 block and page both hit
    '{32'h1234_6000, 1'b0, 1'b0, 32'h0000_0000},  // R7 empty set
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}   // R7 nothing mapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic blk_wr(input logic [1:0] idx, input logic v, input logic [31:0] ea,
                        input logic [31:0] pa, input logic [10:0] m);
    @(negedge clk);
    bw_en = 1'b1; bw_idx = idx; bw_valid = v;
    bw_ebase = ea[31:17]; bw_pbase = pa[31:17]; bw_mask = m;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic pg_wr(input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    pw_en = 1'b1; pw_vpn = vpn; pw_ppn = ppn;
    @(negedge clk);
    pw_en = 1'b0;
  endtask

  // Presents one lookup; returns at the negedge after the result register loads
  task automatic look(input logic [31:0] ea);
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = ea;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] ea, input logic src,
                            input logic [31:0] pa);
    look(ea);
    chk({req, " hit"}, {29'd0, res_valid, res_hit, res_miss}, 32'b110);
    chk({req, " src"}, {31'd0, res_src}, {31'd0, src});
    chk({req, " pa"}, res_pa, pa);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] ea);
    look(ea);
    chk({req, " miss"}, {29'd0, res_valid, res_hit, res_miss}, 32'b101);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of the outputs
    chk("R1 idle flags", {29'd0, res_valid, res_hit, res_miss}, 32'd0);
    // R1: nothing valid after reset
    expect_miss("R1", 32'h8000_0000);
    // R2: no result without a request
    @(negedge clk);
    chk("R2 idle valid", {31'd0, res_valid}, 32'd0);

    blk_wr(2'd0, 1'b1, 32'h8000_0000, 32'h0010_0000, 11'h000);
    blk_wr(2'd1, 1'b1, 32'h9000_0000, 32'h2000_0000, 11'h7FF);
    blk_wr(2'd2, 1'b1, 32'h9000_0000, 32'h4000_0000, 11'h00F);
    pg_wr(20'h12345, 20'hABCDE);
    pg_wr(20'h54325, 20'h22222);
    pg_wr(20'h80001, 20'h11111);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].hit) expect_hit($sformatf("vec%0d", i), VECS[i].ea, VECS[i].src, VECS[i].pa);
      else             expect_miss($sformatf("vec%0d", i), VECS[i].ea);
    end

    // R2: back-to-back requests give back-to-back results
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = 32'h1234_5000;
    @(negedge clk);
    lk_ea = 32'h0000_0000;
    chk("R2 first of pair", {30'd0, res_valid, res_hit}, 32'b11);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R2 second of pair", {30'd0, res_valid, res_miss}, 32'b11);

    // R9 then R8: hit way 0 so way 1 is replaced next
    expect_hit("R9 touch way0", 32'h1234_5000, 1'b0, 32'hABCD_E000);
    pg_wr(20'h77705, 20'h33333);
    expect_miss("R8 way1 evicted", 32'h5432_5000);
    expect_hit("R8 way0 kept", 32'h1234_5000, 1'b0, 32'hABCD_E000);
    expect_hit("R8 new page", 32'h7770_5000, 1'b0, 32'h3333_3000);
    // Last hit was way 1, so way 0 goes next
    pg_wr(20'h66605, 20'h44444);
    expect_miss("R9 way0 evicted", 32'h1234_5000);
    expect_hit("R9 way1 kept", 32'h7770_5000, 1'b0, 32'h3333_3000);
    expect_hit("R8 newest page", 32'h6660_5000, 1'b0, 32'h4444_4000);

    // R10: invalidate entry 1, entry 2 now serves the overlap
    blk_wr(2'd1, 1'b0, 32'h9000_0000, 32'h2000_0000, 11'h7FF);
    expect_hit("R10 fallthrough", 32'h9000_5000, 1'b1, 32'h4000_5000);
    expect_miss("R10 invalid entry", 32'h9ABC_DEF0);
    // R3: a compared bit inside the 2 MB entry breaks the match
    expect_miss("R3 compared bit", 32'h9020_0000);
    // R4: entry 3 overlaps entry 2 but has the higher index
    blk_wr(2'd3, 1'b1, 32'h9000_0000, 32'h6000_0000, 11'h00F);
    expect_hit("R4 lower index", 32'h9001_0000, 1'b1, 32'h4001_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule